// File: doc/BRIEF.md
# Fine-Grain Four-Thread Issue Selector

This block chooses, in every cycle, which of several hardware threads feeds a shared single-issue in-order pipeline. The thread it names supplies the pair of instructions fetched in that cycle. For each thread the block keeps a wait flag. The flag is raised when the thread is chosen while its head instruction is a long-latency kind, as reported by the predecode class bits. It is also raised when the pipeline signals a stall for that thread, such as a cache miss, a trap or a structural hazard. The flag drops once the matching completion pulse arrives.

Threads that are ready and not running ahead of an unresolved load are served in round-robin order. Threads that are running speculatively past a load are picked only when no fully ready thread exists. When nothing can be picked, the block emits a bubble. A separate grant output hands the shared divider to the requesting thread that was selected least recently. This order is kept as an age list that is refreshed on every selection.

Top module: `fg_thread_sel`

## Requirements
- R1: After reset no thread is waiting, the round-robin search begins at thread 0, and the age list runs 0,1,2,3 from least to most recent.
- R2: A thread is eligible when its `thr_active` bit is 1, its wait flag is clear and its `stall_evt` bit is 0 in that cycle. `sel_vld`=1 only ever names an eligible thread.
- R3: Predecode class codes are 3 bits: 0 simple, 1 load, 2 multiply, 3 divide, 4 branch. Codes 5 to 7 count as simple. When a thread is selected while its class is 1 to 4, it is not eligible from the next cycle on.
- R4: A `stall_evt` pulse removes the thread from selection in the same cycle and keeps it waiting from the next cycle on.
- R5: An `evt_done` pulse for a waiting thread makes it eligible again in the next cycle. If a raise and `evt_done` fall in the same cycle, the raise wins.
- R6: Among fully ready threads (eligible with `spec_dep`=0), the pick is the first one found searching upward with wraparound, starting one past the thread selected last.
- R7: A thread with `spec_dep`=1 is picked only when no fully ready thread exists. Such threads use the same round-robin search.
- R8: When no thread is eligible, `sel_vld`=0 and `sel_tid`=0.
- R9: When `div_free`=1, `div_gnt` is one-hot on the requesting thread that comes first in the age list. When `div_free`=0 or no thread requests, `div_gnt`=0.
- R10: Each selection moves the selected thread to the most-recent end of the age list. A bubble leaves the list unchanged.
- R11: Selecting a thread whose class is simple (0) leaves it eligible in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_active | input | NUM_THREADS | Thread has instructions to fetch |
| spec_dep | input | NUM_THREADS | Thread issues speculatively past a pending load |
| stall_evt | input | NUM_THREADS | Pipeline stall event for the thread |
| evt_done | input | NUM_THREADS | Completion of the thread's pending event |
| head_cls | input | 3*NUM_THREADS | Predecode class of each thread's next instruction |
| div_req | input | NUM_THREADS | Thread wants the shared divider |
| div_free | input | 1 | Divider can accept an operation |
| sel_vld | output | 1 | A thread is selected this cycle |
| sel_tid | output | $clog2(NUM_THREADS) | Selected thread id |
| div_gnt | output | NUM_THREADS | One-hot divider grant |

## Verification
The assertions assume the inputs are settled between clock edges. They also assume each `head_cls` field carries one of the five defined codes, or a value the block may treat as simple. The bench changes inputs only at the falling edge and draws class codes from 0 to 4. The bench does raise `evt_done` for threads that are not waiting, and `stall_evt` for inactive threads, because the block must tolerate both. A behavioural model, built from queues and integers, follows every cycle and predicts both the selection and the divider grant.

// File: rtl/fgts_pkg.sv
package fgts_pkg;
   localparam int CLS_W = 3;

   typedef enum logic [CLS_W-1:0] {
      CLS_SIMPLE = 3'd0,
      CLS_LOAD   = 3'd1,
      CLS_MUL    = 3'd2,
      CLS_DIV    = 3'd3,
      CLS_BRANCH = 3'd4
   } insn_cls_e;

   function automatic logic is_long(input logic [CLS_W-1:0] c);
      return (c == CLS_LOAD) || (c == CLS_MUL) || (c == CLS_DIV) || (c == CLS_BRANCH);
   endfunction
endpackage

// File: rtl/fgts_pend.sv
module fgts_pend #(
   parameter int NUM_THREADS = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_THREADS-1:0] raise,
   input  logic [NUM_THREADS-1:0] clear,
   output logic [NUM_THREADS-1:0] waiting
);
   for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
      logic w_q;
      always_ff @(posedge clk) begin
         if (!rst_n)          w_q <= 1'b0;
         else if (raise[t])   w_q <= 1'b1;
         else if (clear[t])   w_q <= 1'b0;
      end
      assign waiting[t] = w_q;

      // R5: raise wins, clear alone releases next cycle
      a_r5_raise_wins: assert property (@(posedge clk) disable iff (!rst_n)
         raise[t] |=> waiting[t]);
      a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
         (clear[t] && !raise[t]) |=> !waiting[t]);
   end
endmodule

// File: rtl/fgts_rr.sv
module fgts_rr #(
   parameter int NUM_THREADS = 4,
   localparam int TID_W = $clog2(NUM_THREADS)
) (
   input  logic [NUM_THREADS-1:0] req,
   input  logic [TID_W-1:0]       last,
   output logic                   hit,
   output logic [TID_W-1:0]       pick
);
   always_comb begin
      hit  = 1'b0;
      pick = '0;
      for (int k = 1; k <= NUM_THREADS; k++) begin
         logic [TID_W-1:0] idx;
         idx = last + TID_W'(k);
         if (!hit && req[idx]) begin
            hit  = 1'b1;
            pick = idx;
         end
      end
   end
endmodule

// File: rtl/fgts_age.sv
module fgts_age #(
   parameter int NUM_THREADS = 4,
   localparam int TID_W = $clog2(NUM_THREADS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   upd,
   input  logic [TID_W-1:0]       upd_tid,
   input  logic [NUM_THREADS-1:0] div_req,
   input  logic                   div_free,
   output logic [NUM_THREADS-1:0] div_gnt
);
   logic [TID_W-1:0] age_q [NUM_THREADS];
   logic [TID_W-1:0] age_d [NUM_THREADS];
   logic [NUM_THREADS-1:0] seen;

   always_comb begin
      int pos;
      pos = 0;
      for (int i = 0; i < NUM_THREADS; i++)
         if (age_q[i] == upd_tid) pos = i;
      for (int i = 0; i < NUM_THREADS; i++) begin
         if (!upd || i < pos)        age_d[i] = age_q[i];
         else if (i == NUM_THREADS-1) age_d[i] = upd_tid;
         else                         age_d[i] = age_q[(i+1) % NUM_THREADS];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_THREADS; i++) age_q[i] <= TID_W'(i);
      end else begin
         for (int i = 0; i < NUM_THREADS; i++) age_q[i] <= age_d[i];
      end
   end

   always_comb begin
      logic found;
      found   = 1'b0;
      div_gnt = '0;
      if (div_free) begin
         for (int i = 0; i < NUM_THREADS; i++) begin
            if (!found && div_req[age_q[i]]) begin
               found = 1'b1;
               div_gnt[age_q[i]] = 1'b1;
            end
         end
      end
   end

   always_comb begin
      seen = '0;
      for (int i = 0; i < NUM_THREADS; i++) seen[age_q[i]] = 1'b1;
   end

   // R10: the age list always holds every thread exactly once
   a_r10_age_perm: assert property (@(posedge clk) disable iff (!rst_n)
      &seen);
   // R9: grant is one-hot, only to a requester, only when divider free
   a_r9_gnt_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(div_gnt));
   a_r9_gnt_legal: assert property (@(posedge clk) disable iff (!rst_n)
      (div_gnt != '0) |-> (div_free && ((div_gnt & ~div_req) == '0)));
endmodule

// File: rtl/fg_thread_sel.sv
module fg_thread_sel
   import fgts_pkg::*;
#(
   parameter int NUM_THREADS = 4
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [NUM_THREADS-1:0]           thr_active,
   input  logic [NUM_THREADS-1:0]           spec_dep,
   input  logic [NUM_THREADS-1:0]           stall_evt,
   input  logic [NUM_THREADS-1:0]           evt_done,
   input  logic [CLS_W*NUM_THREADS-1:0]     head_cls,
   input  logic [NUM_THREADS-1:0]           div_req,
   input  logic                             div_free,
   output logic                             sel_vld,
   output logic [$clog2(NUM_THREADS)-1:0]   sel_tid,
   output logic [NUM_THREADS-1:0]           div_gnt
);
   localparam int TID_W = $clog2(NUM_THREADS);

   if (NUM_THREADS < 2 || (NUM_THREADS & (NUM_THREADS-1)) != 0) begin : g_bad_cfg
      $error("NUM_THREADS must be a power of two, at least 2");
   end

   logic [CLS_W-1:0]       cls_a [NUM_THREADS];
   logic [NUM_THREADS-1:0] waiting, eligible, full_rdy, low_rdy, long_sel, raise;
   logic                   hit_f, hit_l;
   logic [TID_W-1:0]       pick_f, pick_l, last_q;

   for (genvar t = 0; t < NUM_THREADS; t++) begin : g_cls
      assign cls_a[t]    = head_cls[t*CLS_W +: CLS_W];
      assign long_sel[t] = sel_vld && (sel_tid == TID_W'(t)) && is_long(cls_a[t]);
   end

   assign eligible = thr_active & ~waiting & ~stall_evt;
   assign full_rdy = eligible & ~spec_dep;
   assign low_rdy  = eligible & spec_dep;
   assign raise    = stall_evt | long_sel;

   fgts_pend #(.NUM_THREADS(NUM_THREADS)) u_pend (
      .clk(clk), .rst_n(rst_n), .raise(raise), .clear(evt_done), .waiting(waiting));

   fgts_rr #(.NUM_THREADS(NUM_THREADS)) u_rr_full (
      .req(full_rdy), .last(last_q), .hit(hit_f), .pick(pick_f));

   fgts_rr #(.NUM_THREADS(NUM_THREADS)) u_rr_low (
      .req(low_rdy), .last(last_q), .hit(hit_l), .pick(pick_l));

   assign sel_vld = hit_f | hit_l;
   assign sel_tid = hit_f ? pick_f : (hit_l ? pick_l : '0);

   always_ff @(posedge clk) begin
      if (!rst_n)       last_q <= TID_W'(NUM_THREADS-1);
      else if (sel_vld) last_q <= sel_tid;
   end

   fgts_age #(.NUM_THREADS(NUM_THREADS)) u_age (
      .clk(clk), .rst_n(rst_n), .upd(sel_vld), .upd_tid(sel_tid),
      .div_req(div_req), .div_free(div_free), .div_gnt(div_gnt));

   // R2: only eligible threads are named
   a_r2_sel_eligible: assert property (@(posedge clk) disable iff (!rst_n)
      sel_vld |-> eligible[sel_tid]);
   // R7: speculative pick only when no fully ready thread
   a_r7_low_last: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_vld && spec_dep[sel_tid]) |-> (full_rdy == '0));
   // R8: bubble only when nothing eligible, with id zero
   a_r8_bubble: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_vld |-> (eligible == '0 && sel_tid == '0));
   // R3: long-latency selection blocks the thread next cycle
   a_r3_long_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_vld && is_long(cls_a[sel_tid])) |=> waiting[$past(sel_tid)]);
   // R4: a stalled thread is never picked in the stall cycle
   a_r4_stall_now: assert property (@(posedge clk) disable iff (!rst_n)
      sel_vld |-> !stall_evt[sel_tid]);
endmodule

// File: tb/tb_fg_thread_sel.sv
`timescale 1ns/1ps
module tb_fg_thread_sel;
   localparam int N = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N-1:0] thr_active = '0, spec_dep = '0, stall_evt = '0, evt_done = '0, div_req = '0;
   logic [3*N-1:0] head_cls = '0;
   logic div_free = 1'b0;
   logic sel_vld;
   logic [1:0] sel_tid;
   logic [N-1:0] div_gnt;

   int n_chk = 0, n_fail = 0;
   bit done_flag = 0;

   // model state
   bit m_wait [N];
   int m_last = N-1;
   int m_age [$];

   always #10 clk = ~clk;

   fg_thread_sel #(.NUM_THREADS(N)) dut (
      .clk(clk), .rst_n(rst_n), .thr_active(thr_active), .spec_dep(spec_dep),
      .stall_evt(stall_evt), .evt_done(evt_done), .head_cls(head_cls),
      .div_req(div_req), .div_free(div_free),
      .sel_vld(sel_vld), .sel_tid(sel_tid), .div_gnt(div_gnt));

   task automatic check(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int cls_of(int t);
      return int'(head_cls[t*3 +: 3]);
   endfunction

   // one cycle: inputs already driven at falling edge
   task automatic cycle(string tag);
      int e_vld, e_tid, e_gnt, pick_tag;
      bit elig [N];
      #2;
      e_vld = 0; e_tid = 0; pick_tag = 8;
      for (int t = 0; t < N; t++) elig[t] = thr_active[t] && !m_wait[t] && !stall_evt[t];
      for (int k = 1; k <= N; k++) begin
         int i; i = (m_last + k) % N;
         if (!e_vld && elig[i] && !spec_dep[i]) begin e_vld = 1; e_tid = i; pick_tag = 6; end
      end
      for (int k = 1; k <= N; k++) begin
         int i; i = (m_last + k) % N;
         if (!e_vld && elig[i] && spec_dep[i]) begin e_vld = 1; e_tid = i; pick_tag = 7; end
      end
      e_gnt = 0;
      if (div_free)
         foreach (m_age[j]) if (e_gnt == 0 && div_req[m_age[j]]) e_gnt = 1 << m_age[j];
      check($sformatf("%s R%0d sel_vld", tag, pick_tag), int'(sel_vld), e_vld);
      check($sformatf("%s R%0d sel_tid", tag, pick_tag), int'(sel_tid), e_tid);
      check($sformatf("%s R9 div_gnt", tag), int'(div_gnt), e_gnt);
      // advance model
      for (int t = 0; t < N; t++) begin
         bit lng; int c; c = cls_of(t);
         lng = e_vld && e_tid == t && c >= 1 && c <= 4;
         if (stall_evt[t] || lng) m_wait[t] = 1;
         else if (evt_done[t]) m_wait[t] = 0;
      end
      if (e_vld) begin
         m_last = e_tid;
         foreach (m_age[j]) if (m_age[j] == e_tid) begin m_age.delete(j); break; end
         m_age.push_back(e_tid);
      end
   endtask

   task automatic drive(logic [N-1:0] act, logic [N-1:0] sp, logic [N-1:0] st,
                        logic [N-1:0] dn, logic [3*N-1:0] cl, logic [N-1:0] dr, logic df);
      @(negedge clk);
      thr_active = act; spec_dep = sp; stall_evt = st; evt_done = dn;
      head_cls = cl; div_req = dr; div_free = df;
   endtask

   initial begin
      m_age = {0, 1, 2, 3};
      for (int t = 0; t < N; t++) m_wait[t] = 0;
      repeat (3) @(negedge clk);
      // R1: reset state, age list 0..3 gives divider to thread 0, bubble when idle (R8)
      div_req = '1; div_free = 1'b1;
      @(posedge clk); #2;
      check("R1 reset sel_vld", int'(sel_vld), 0);
      check("R1 reset div_gnt", int'(div_gnt), 1);
      @(negedge clk); rst_n = 1'b1;
      // R1/R6: search begins at thread 0, then round robin
      drive('1, '0, '0, '0, '0, '0, 1'b0); cycle("R1");
      repeat (5) begin drive('1, '0, '0, '0, '0, '0, 1'b0); cycle("R6"); end
      // R11: simple class keeps the thread going
      repeat (3) begin drive(4'b0001, '0, '0, '0, '0, '0, 1'b0); cycle("R11"); end
      // R3: thread 1 load blocks it
      drive(4'b0010, '0, '0, '0, 12'h008, '0, 1'b0); cycle("R3");
      repeat (2) begin drive(4'b0010, '0, '0, '0, '0, '0, 1'b0); cycle("R3"); end
      // R5: completion releases next cycle; same-cycle raise wins
      drive(4'b0010, '0, '0, 4'b0010, '0, '0, 1'b0); cycle("R5");
      drive(4'b0010, '0, 4'b0010, 4'b0010, '0, '0, 1'b0); cycle("R5");
      drive(4'b0010, '0, '0, '0, '0, '0, 1'b0); cycle("R5");
      drive(4'b0010, '0, '0, 4'b0010, '0, '0, 1'b0); cycle("R5");
      drive(4'b0010, '0, '0, '0, '0, '0, 1'b0); cycle("R5");
      // R4: stall on thread 2
      drive(4'b0100, '0, 4'b0100, '0, '0, '0, 1'b0); cycle("R4");
      drive(4'b0100, '0, '0, '0, '0, '0, 1'b0); cycle("R4");
      drive(4'b0100, '0, '0, 4'b0100, '0, '0, 1'b0); cycle("R4");
      // R7: speculative threads only when none fully ready
      drive(4'b1111, 4'b0111, '0, '0, '0, '0, 1'b0); cycle("R7");
      repeat (3) begin drive(4'b0111, 4'b0111, '0, '0, '0, '0, 1'b0); cycle("R7"); end
      // R8: nothing eligible
      drive(4'b0000, '0, '0, '0, '0, '0, 1'b0); cycle("R8");
      // R9/R10: divider to least recently selected
      drive(4'b1000, '0, '0, '0, '0, 4'b1111, 1'b1); cycle("R10");
      drive(4'b0000, '0, '0, '0, '0, 4'b1111, 1'b1); cycle("R9");
      drive(4'b0000, '0, '0, '0, '0, 4'b1111, 1'b0); cycle("R9");
      // random mix
      for (int c = 0; c < 4000; c++) begin
         logic [3*N-1:0] cl;
         for (int t = 0; t < N; t++) cl[t*3 +: 3] = 3'($urandom_range(0, 4));
         drive(4'($urandom) | 4'($urandom), 4'($urandom) & 4'($urandom),
               ($urandom_range(0, 7) == 0) ? 4'(1 << $urandom_range(0, 3)) : 4'b0,
               4'($urandom) & 4'($urandom), cl, 4'($urandom), 1'($urandom));
         cycle("RND");
      end
      done_flag = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      #3000000;
      if (!done_flag) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end
endmodule